// File: doc/BRIEF.md
# Move-Only Processor with One-Shot Store Suppression

This block is a minimal processor whose single instruction copies one word from a source address to a destination address. An instruction is two consecutive words in memory: the source address first, then the destination address. Arithmetic, flags and control flow are reached by moving words to and from a few reserved addresses at the top of the address space. These addresses hold the program counter, an accumulator, an adder input and a sign flag.

A store-suppression flag adds conditional branching. A move of a nonzero word to the suppression address arms the flag. The store of the next instruction is then dropped, and that includes a store to the program counter. The flag clears itself once that instruction finishes. A pair of moves therefore acts as a conditional jump. The program counter can also be read, and a true flag reads as the size of one instruction. Adding the flag to the program counter gives a conditional skip.

All fetches, operand loads and stores go through one synchronous memory port. Read data is returned in the cycle after the request.

Top module: `move_cpu`

## Requirements
- R1: During reset, and in the first cycle after reset is released, the port requests a read of address 0 with the write strobe low. The program counter, the accumulator and the suppression flag are all cleared by reset.
- R2: Each instruction takes four cycles. Cycle 1 reads the source word at PC. Cycle 2 reads the destination word at PC+1 and advances PC by 2. Cycle 3 reads the operand at the source address. Cycle 4 writes the operand to the destination address.
- R3: A move between two ordinary memory addresses copies the source word unchanged to the destination.
- R4: A store to 0xFFFF loads the program counter, so execution continues at the stored address.
- R5: A read of 0xFFFF returns the address of the instruction that follows the one executing.
- R6: 0xFFF0 is the accumulator, which can be written and read back. Reserved addresses never appear on the memory port.
- R7: A store to 0xFFF1 adds the stored word to the accumulator, modulo 2^16. A read of 0xFFF1 returns 0.
- R8: A read of 0xFFF2 returns 2 when accumulator bit 15 is set and 0 otherwise. A store to 0xFFF2 has no effect.
- R9: A store of a nonzero word to 0xFFFE arms the suppression flag. A store of zero leaves the flag clear. A read of 0xFFFE returns 0.
- R10: While the flag is armed, the store of the next instruction is dropped, whether its destination is memory, the PC, the accumulator or the adder. The flag is cleared at the end of that instruction, so the store after it takes place.
- R11: The port never asserts the read and write strobes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Memory word address |
| mem_re | output | 1 | Read request; data is returned in the next cycle |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data from the previous cycle's request |

## Verification
The bench sweeps pairs of operands through the accumulator and the adder. It targets carry wrap and the sign boundary at 0x7FFF/0x8000, where a wrong adder width or a wrong sign bit would give the wrong sum or a flipped flag. Conditional-jump and skip programs run on both signs. A flag that failed to block a PC store would take the jump. A flag that never cleared would also swallow the marker store that follows.

Arming values are swept, including zero. A flag that responded to any store rather than to a nonzero one would drop a store it should keep. A reserved address that leaked onto the port would show up as an out-of-range bus access.

// File: rtl/move_cpu_pkg.sv
package move_cpu_pkg;

  typedef enum logic [1:0] {
    ST_FSRC  = 2'd0,
    ST_FDST  = 2'd1,
    ST_READ  = 2'd2,
    ST_WRITE = 2'd3
  } step_t;

  typedef enum logic [2:0] {
    MAP_NONE = 3'd0,
    MAP_ACC  = 3'd1,
    MAP_ADD  = 3'd2,
    MAP_CCN  = 3'd3,
    MAP_INH  = 3'd4,
    MAP_PC   = 3'd5
  } map_t;

  localparam int INSTR_WORDS = 2;

endpackage

// File: rtl/move_cpu_decode.sv
module move_cpu_decode
  import move_cpu_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] addr,
  output map_t              sel
);

  localparam logic [WORD_W-1:0] TOP_A = {WORD_W{1'b1}};
  localparam logic [WORD_W-1:0] PC_A  = TOP_A;
  localparam logic [WORD_W-1:0] INH_A = TOP_A - WORD_W'(1);
  localparam logic [WORD_W-1:0] ACC_A = TOP_A - WORD_W'(15);
  localparam logic [WORD_W-1:0] ADD_A = TOP_A - WORD_W'(14);
  localparam logic [WORD_W-1:0] CCN_A = TOP_A - WORD_W'(13);

  always_comb begin
    if (addr == PC_A)       sel = MAP_PC;
    else if (addr == INH_A) sel = MAP_INH;
    else if (addr == ACC_A) sel = MAP_ACC;
    else if (addr == ADD_A) sel = MAP_ADD;
    else if (addr == CCN_A) sel = MAP_CCN;
    else                    sel = MAP_NONE;
  end

endmodule

// File: rtl/move_cpu_seq.sv
module move_cpu_seq
  import move_cpu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  output step_t step
);

  step_t step_d;

  always_comb begin
    case (step)
      ST_FSRC:  step_d = ST_FDST;
      ST_FDST:  step_d = ST_READ;
      ST_READ:  step_d = ST_WRITE;
      default:  step_d = ST_FSRC;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step <= ST_FSRC;
    else        step <= step_d;
  end

  // R2
  step_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_WRITE) |=> (step == ST_FSRC));

endmodule

// File: rtl/move_cpu_regs.sv
module move_cpu_regs
  import move_cpu_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  step_t             step,
  input  map_t              wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] pc_q,
  output logic [WORD_W-1:0] acc_q,
  output logic              inh_q
);

  localparam logic [WORD_W-1:0] PC_STEP = WORD_W'(INSTR_WORDS);

  logic              wr_live;
  logic              pc_en, acc_en, inh_en;
  logic [WORD_W-1:0] pc_d, acc_d;
  logic              inh_d;

  always_comb begin
    wr_live = (step == ST_WRITE) && !inh_q;

    pc_en = (step == ST_FDST) || (wr_live && (wr_sel == MAP_PC));
    pc_d  = (step == ST_FDST) ? (pc_q + PC_STEP) : wr_data;

    acc_en = wr_live && ((wr_sel == MAP_ACC) || (wr_sel == MAP_ADD));
    acc_d  = (wr_sel == MAP_ADD) ? (acc_q + wr_data) : wr_data;

    inh_en = (step == ST_WRITE);
    inh_d  = wr_live && (wr_sel == MAP_INH) && (|wr_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      acc_q <= '0;
      inh_q <= 1'b0;
    end else begin
      if (pc_en)  pc_q  <= pc_d;
      if (acc_en) acc_q <= acc_d;
      if (inh_en) inh_q <= inh_d;
    end
  end

  // R2
  pc_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_FDST) |=> (pc_q == $past(pc_q) + PC_STEP));

  // R10
  inh_oneshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inh_q && step == ST_WRITE) |=> !inh_q);

  // R10
  inh_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step != ST_WRITE) |=> $stable(inh_q));

  // R10
  acc_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inh_q && step == ST_WRITE) |=> $stable(acc_q) && $stable(pc_q));

endmodule

// File: rtl/move_cpu.sv
module move_cpu
  import move_cpu_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [WORD_W-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata
);

  localparam logic [WORD_W-1:0] TRUE_CC = WORD_W'(INSTR_WORDS);

  logic              rst_meta, srst_n;
  step_t             step;
  map_t              src_sel, dst_sel;
  logic [WORD_W-1:0] src_q, dst_q, opnd_q;
  logic [WORD_W-1:0] opnd_d, operand;
  logic [WORD_W-1:0] pc_q, acc_q;
  logic              inh_q;
  logic              src_en, dst_en, opnd_en;

  // reset: asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      srst_n   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      srst_n   <= rst_meta;
    end
  end

  move_cpu_seq i_seq (
    .clk   (clk),
    .rst_n (srst_n),
    .step  (step)
  );

  move_cpu_decode #(.WORD_W(WORD_W)) i_dec_src (
    .addr (src_q),
    .sel  (src_sel)
  );

  move_cpu_decode #(.WORD_W(WORD_W)) i_dec_dst (
    .addr (dst_q),
    .sel  (dst_sel)
  );

  move_cpu_regs #(.WORD_W(WORD_W)) i_regs (
    .clk     (clk),
    .rst_n   (srst_n),
    .step    (step),
    .wr_sel  (dst_sel),
    .wr_data (operand),
    .pc_q    (pc_q),
    .acc_q   (acc_q),
    .inh_q   (inh_q)
  );

  // next-state of the instruction latches and the mapped operand
  always_comb begin
    src_en  = (step == ST_FDST);
    dst_en  = (step == ST_READ);
    opnd_en = (step == ST_READ);
    case (src_sel)
      MAP_ACC: opnd_d = acc_q;
      MAP_CCN: opnd_d = acc_q[WORD_W-1] ? TRUE_CC : '0;
      MAP_PC:  opnd_d = pc_q;
      default: opnd_d = '0;
    endcase
    operand = (src_sel == MAP_NONE) ? mem_rdata : opnd_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      opnd_q <= '0;
    end else begin
      if (src_en)  src_q  <= mem_rdata;
      if (dst_en)  dst_q  <= mem_rdata;
      if (opnd_en) opnd_q <= opnd_d;
    end
  end

  // memory port
  always_comb begin
    mem_re    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = pc_q;
    mem_wdata = operand;
    case (step)
      ST_FSRC: begin
        mem_re   = 1'b1;
        mem_addr = pc_q;
      end
      ST_FDST: begin
        mem_re   = 1'b1;
        mem_addr = pc_q + WORD_W'(1);
      end
      ST_READ: begin
        mem_re   = (src_sel == MAP_NONE);
        mem_addr = src_q;
      end
      default: begin
        mem_we   = !inh_q && (dst_sel == MAP_NONE);
        mem_addr = dst_q;
      end
    endcase
  end

  // R10
  no_store_inh_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (inh_q && step == ST_WRITE) |-> !mem_we);

  // R11
  port_excl_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !(mem_re && mem_we));

  // R2
  we_slot_chk: assert property (@(posedge clk) disable iff (!srst_n)
    mem_we |-> (step == ST_WRITE));

  // R6
  map_hidden_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (mem_we && step == ST_WRITE) |-> (dst_sel == MAP_NONE));

endmodule

// File: tb/test_move_cpu.sv
module test_move_cpu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_re, mem_we;
  logic [15:0] mem [0:255];
  int          checks = 0;
  int          fails = 0;
  int          stray = 0;

  always #5 clk = ~clk;

  move_cpu i_move_cpu (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_re    (mem_re),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  // synchronous memory, low 256 words
  always @(posedge clk) begin
    if ((mem_we || mem_re) && mem_addr[15:8] != 8'h00) stray = stray + 1;
    if (mem_we && mem_addr[15:8] == 8'h00) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  endtask

  task automatic put(input int idx, input logic [15:0] s, input logic [15:0] d);
    mem[2*idx]   = s;
    mem[2*idx+1] = d;
  endtask

  task automatic start();
    rst_n = 1'b0;
    stray = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] pat(input int i);
    case (i)
      0: pat = 16'h0000;
      1: pat = 16'h0001;
      2: pat = 16'h0002;
      3: pat = 16'h7FFF;
      4: pat = 16'h8000;
      5: pat = 16'h8001;
      6: pat = 16'hFFFF;
      default: pat = 16'h1234;
    endcase
  endfunction

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0001, 16'h0000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // ---- R1: reset state
    clear_mem();
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 re in reset", {15'd0, mem_re}, 16'd1);
    chk("R1 addr in reset", mem_addr, 16'h0000);
    chk("R1 we in reset", {15'd0, mem_we}, 16'd0);

    // ---- R2/R3/R5: plain move, cycle order, PC readback
    clear_mem();
    mem[100] = 16'hC3A5;
    mem[103] = 16'd4;
    put(0, 16'd100, 16'd101);
    put(1, 16'hFFFF, 16'd102);
    put(2, 16'd103, 16'hFFFF);
    start();
    @(negedge clk);
    chk("R1 first fetch addr", mem_addr, 16'h0000);
    begin
      int n = 0;
      while (!(mem_re && mem_addr == 16'd1) && n < 10) begin
        @(negedge clk);
        n++;
      end
    end
    chk("R2 dst fetch addr", mem_addr, 16'd1);
    @(negedge clk);
    chk("R2 operand read re", {15'd0, mem_re}, 16'd1);
    chk("R2 operand read addr", mem_addr, 16'd100);
    @(negedge clk);
    chk("R2 store we", {15'd0, mem_we}, 16'd1);
    chk("R2 store addr", mem_addr, 16'd101);
    chk("R3 store data", mem_wdata, 16'hC3A5);
    @(negedge clk);
    chk("R2 next fetch at pc+2", mem_addr, 16'd2);
    run(30);
    chk("R3 copied word", mem[101], 16'hC3A5);
    chk("R5 pc readback", mem[102], 16'd4);
    chk("R6 no reserved on port", 16'(stray), 16'd0);

    // ---- R6/R7/R8: accumulator, adder and sign flag sweep
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        logic [15:0] sum;
        sum = pat(a) + pat(b);
        clear_mem();
        mem[100] = pat(a);
        mem[101] = pat(b);
        mem[104] = 16'h5555;
        mem[105] = 16'h1234;
        mem[108] = 16'd14;
        put(0, 16'd100, 16'hFFF0);
        put(1, 16'd101, 16'hFFF1);
        put(2, 16'hFFF0, 16'd102);
        put(3, 16'hFFF2, 16'd103);
        put(4, 16'hFFF1, 16'd104);
        put(5, 16'd105, 16'hFFF2);
        put(6, 16'hFFF2, 16'd106);
        put(7, 16'd108, 16'hFFFF);
        start();
        run(50);
        chk("R7 sum", mem[102], sum);
        chk("R8 sign flag", mem[103], sum[15] ? 16'd2 : 16'd0);
        chk("R7 adder reads zero", mem[104], 16'd0);
        chk("R8 flag write ignored", mem[106], sum[15] ? 16'd2 : 16'd0);
        chk("R6 no reserved on port", 16'(stray), 16'd0);
      end
    end

    // ---- R4/R10: conditional jump pair
    for (int a = 0; a < 8; a++) begin
      logic neg;
      neg = pat(a)[15];
      clear_mem();
      mem[100] = pat(a);
      mem[101] = 16'd20;
      mem[102] = 16'hAAAA;
      mem[104] = 16'h4444;
      mem[106] = 16'd10;
      mem[107] = 16'hBBBB;
      mem[109] = 16'd22;
      put(0, 16'd100, 16'hFFF0);
      put(1, 16'hFFF2, 16'hFFFE);
      put(2, 16'd101, 16'hFFFF);
      put(3, 16'd102, 16'd103);
      put(4, 16'd104, 16'd105);
      put(5, 16'd106, 16'hFFFF);
      put(10, 16'd107, 16'd108);
      put(11, 16'd109, 16'hFFFF);
      start();
      run(50);
      chk("R10 fallthrough marker", mem[103], neg ? 16'hAAAA : 16'h0000);
      chk("R10 one store dropped only", mem[105], neg ? 16'h4444 : 16'h0000);
      chk("R4 jump target marker", mem[108], neg ? 16'h0000 : 16'hBBBB);
    end

    // ---- R5/R8: skip built from flag + PC
    for (int a = 0; a < 8; a++) begin
      logic neg;
      neg = pat(a)[15];
      clear_mem();
      mem[100] = pat(a);
      mem[102] = 16'hAAAA;
      mem[104] = 16'h4444;
      mem[106] = 16'd16;
      mem[110] = 16'd4;
      mem[111] = 16'd10;
      put(0, 16'd100, 16'hFFF0);
      put(1, 16'hFFF2, 16'hFFF0);
      put(2, 16'd110, 16'hFFF1);
      put(3, 16'hFFFF, 16'hFFF1);
      put(4, 16'hFFF0, 16'hFFFF);
      put(5, 16'd111, 16'hFFFF);
      put(6, 16'd102, 16'd103);
      put(7, 16'd104, 16'd105);
      put(8, 16'd106, 16'hFFFF);
      start();
      run(60);
      chk("R5 skip target", mem[103], neg ? 16'h0000 : 16'hAAAA);
      chk("R5 after skip", mem[105], 16'h4444);
    end

    // ---- R9/R10: arming value sweep, memory and accumulator stores
    for (int k = 0; k < 8; k++) begin
      logic arm;
      arm = (pat(k) != 16'h0000);
      clear_mem();
      mem[100] = pat(k);
      mem[101] = 16'hC0DE;
      mem[104] = 16'd10;
      mem[105] = 16'h0777;
      put(0, 16'd100, 16'hFFFE);
      put(1, 16'd101, 16'd102);
      put(2, 16'd101, 16'd103);
      put(3, 16'hFFFE, 16'd106);
      put(4, 16'd105, 16'hFFFE);
      put(5, 16'd101, 16'hFFF0);
      put(6, 16'hFFF0, 16'd107);
      put(7, 16'd101, 16'hFFF1);
      put(8, 16'hFFF0, 16'd108);
      put(9, 16'd104, 16'hFFFF);
      mem[104] = 16'd18;
      start();
      run(60);
      chk("R9 arm gates store", mem[102], arm ? 16'h0000 : 16'hC0DE);
      chk("R10 store after drop", mem[103], 16'hC0DE);
      chk("R9 flag reads zero", mem[106], 16'h0000);
      chk("R10 acc store dropped", mem[107], 16'h0000);
      chk("R10 adder store runs", mem[108], 16'hC0DE);
    end

    // ---- R11 sampled over a short run
    clear_mem();
    put(0, 16'd100, 16'd101);
    put(1, 16'd104, 16'hFFFF);
    mem[104] = 16'd2;
    start();
    for (int c = 0; c < 24; c++) begin
      @(negedge clk);
      chk("R11 strobes exclusive", {15'd0, mem_re && mem_we}, 16'd0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule